// File: doc/BRIEF.md
# Cross-Clock Register Bridge with Bus Stall

This block is the register front end of a peripheral whose working logic runs on a core clock that is unrelated to the bus clock. Every register has a fixed synchronization class. Some registers must cross into the core domain when written, some must fetch their value from the core domain when read, one does both, and the rest live entirely on the bus side. A crossing uses a toggle request and a toggle acknowledge. Each toggle passes through a chain of synchronizer flops, and the payload is held still while a crossing is in flight.

A crossing sets a busy bit that software can read. A second access that also needs a crossing is not dropped while busy is set. The bridge holds `busReady` low until the first crossing ends, and then the held access completes normally. A synchronized read always stalls its own bus cycle until the core value has arrived. Plain registers answer in one cycle at all times, busy or not.

When a crossing finishes, a sync-done interrupt flag is set. A second flag is set on a rising edge of a core-side event line. Both flags share one request output. That output is gated by an enable mask, which software changes through a set register and a clear register. Each of those two registers acts only on the bits written as one.

Top module: `xclk_reg_bridge`

## Requirements
- R1: Register classes by address: 0 is the control register and crosses on write only (readback returns the last value written); 1 is the core status and crosses on read only (writes are ignored); 2 is the period register and crosses on both write and read; 3 is a scratch register with no crossing. A write to 0 or 2 appears on `coreCtrl` or `corePeriod` once its crossing ends.
- R2: Bit 0 of the status register at address 7 reads 1 from the bus clock edge that accepts a crossing access.
- R3: The busy bit returns to 0 only after the core domain has taken the written value or supplied the read value, and the held payload stays unchanged while busy is 1.
- R4: An access needing a crossing that arrives while busy is 1 sees `busReady` low until busy clears, and then completes with the correct effect.
- R5: An access to a register with no crossing completes with `busReady` high in its first cycle, even while busy is 1.
- R6: A read of address 1 returns the value of `coreStat` sampled in the core domain. A read of address 2 returns the core-side period value. Both reads stall until that value has arrived.
- R7: The flag register at address 4 has bit 0 set when a crossing completes and bit 1 set on a rising edge of `coreEvt`. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R8: Writing 1 to a bit at address 5 sets that enable bit, and writing 1 at address 6 clears it. Writing 0 to either register changes nothing. A read of 5 or 6 returns the enable mask in bits 1:0.
- R9: `irqReq` is high whenever some flag bit and its enable bit are both 1. It stays high until that flag is cleared or that enable is removed.
- R10: After reset the busy bit, the flags, the enables, `irqReq`, `coreCtrl` and `corePeriod` are all 0, and `busReady` is high while the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus clock |
| busRstN | input | 1 | Bus-domain reset, active low, asynchronous |
| busSel | input | 1 | Access valid; held by the master until busReady |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 3 | Register address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, valid while busSel, !busWrite and busReady |
| busReady | output | 1 | Access completes at the clock edge where this is high |
| irqReq | output | 1 | Combined interrupt request |
| coreClk | input | 1 | Core clock |
| coreRstN | input | 1 | Core-domain reset, active low, asynchronous |
| coreStat | input | DATA_W | Core status value fetched by a read of address 1 |
| coreEvt | input | 1 | Core event line; a rising edge sets flag bit 1 |
| coreCtrl | output | DATA_W | Control value applied in the core domain |
| corePeriod | output | DATA_W | Period value applied in the core domain |

## Verification
The checker watches the bus edge on every cycle. It confirms that a crossing write raises busy on the next cycle and that a crossing access is never granted `busReady` while busy is set. It also confirms that plain accesses always get `busReady` at once, that the sync-done flag is already present when busy falls, that the held payload does not move during a crossing, and that the request line only drops after a flag clear or an enable clear. Other behaviour needs whole scenarios in the bench: that values really arrive on `coreCtrl`, `corePeriod` and the read path, that a stalled write or read lands with the right data afterwards, the write-one semantics of the flag and enable registers, event capture, and the state after a reset in mid-run.

// File: rtl/bridge_pkg.sv
`timescale 1ns/1ps
package bridge_pkg;

  localparam int REG_ADDR_W = 3;
  localparam int IRQ_SRC_N  = 2;
  localparam int SRC_DONE   = 0;
  localparam int SRC_EVT    = 1;

  typedef enum logic [REG_ADDR_W-1:0] {
    A_CTRL    = 3'd0,
    A_STAT    = 3'd1,
    A_PERIOD  = 3'd2,
    A_SCRATCH = 3'd3,
    A_FLAG    = 3'd4,
    A_ENSET   = 3'd5,
    A_ENCLR   = 3'd6,
    A_STATUS  = 3'd7
  } regAddrT;

  typedef enum logic [1:0] {
    SYNC_NONE,
    SYNC_WR,
    SYNC_RD,
    SYNC_BOTH
  } syncClassT;

  // control -> datapath strobes, one cycle each
  typedef struct packed {
    logic startXfer;
    logic xferWr;
    logic wrCtrlShadow;
    logic wrScratch;
    logic wrFlag;
    logic wrEnSet;
    logic wrEnClr;
  } strobeT;

  function automatic syncClassT classOf(input logic [REG_ADDR_W-1:0] addr);
    syncClassT cls;
    case (addr)
      A_CTRL:   cls = SYNC_WR;
      A_STAT:   cls = SYNC_RD;
      A_PERIOD: cls = SYNC_BOTH;
      default:  cls = SYNC_NONE;
    endcase
    return cls;
  endfunction

  function automatic logic needsSync(input logic [REG_ADDR_W-1:0] addr, input logic wr);
    syncClassT cls;
    cls = classOf(addr);
    if (wr) return (cls == SYNC_WR) || (cls == SYNC_BOTH);
    return (cls == SYNC_RD) || (cls == SYNC_BOTH);
  endfunction

endpackage

// File: rtl/bridge_sync.sv
`timescale 1ns/1ps
module bridge_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stageQ [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[gi] <= '0;
          else       stageQ[gi] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[gi] <= '0;
          else       stageQ[gi] <= stageQ[gi-1];
        end
      end
    end
  endgenerate

  assign q = stageQ[STAGES-1];

endmodule

// File: rtl/bridge_ctrl.sv
`timescale 1ns/1ps
module bridge_ctrl
  import bridge_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busSel,
  input  logic                  busWrite,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic                  xferDone,
  output logic                  busReady,
  output logic                  busy,
  output strobeT                strobe
);

  typedef enum logic [1:0] {
    S_IDLE,
    S_WAIT,
    S_RDONE
  } stateT;

  stateT state, stateNext;
  logic  pendRead, pendReadNext;
  logic  syncAcc;
  logic  plainWrite;

  assign syncAcc = busSel && needsSync(busAddr, busWrite);

  always_comb begin
    stateNext    = state;
    pendReadNext = pendRead;
    busReady     = 1'b1;
    strobe       = '0;
    unique case (state)
      S_IDLE: begin
        if (syncAcc) begin
          strobe.startXfer    = 1'b1;
          strobe.xferWr       = busWrite;
          strobe.wrCtrlShadow = busWrite && (busAddr == A_CTRL);
          pendReadNext        = !busWrite;
          busReady            = busWrite;   // a write is posted, a read waits
          stateNext           = S_WAIT;
        end
      end
      S_WAIT: begin
        if (syncAcc) busReady = 1'b0;       // stall while a crossing is in flight
        if (xferDone) stateNext = pendRead ? S_RDONE : S_IDLE;
      end
      S_RDONE: begin
        if (busSel && !busWrite) begin      // the held read takes its data now
          pendReadNext = 1'b0;
          stateNext    = S_IDLE;
        end
      end
      default: stateNext = S_IDLE;
    endcase

    plainWrite       = busSel && busWrite && !syncAcc;
    strobe.wrScratch = plainWrite && (busAddr == A_SCRATCH);
    strobe.wrFlag    = plainWrite && (busAddr == A_FLAG);
    strobe.wrEnSet   = plainWrite && (busAddr == A_ENSET);
    strobe.wrEnClr   = plainWrite && (busAddr == A_ENCLR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      pendRead <= 1'b0;
    end else begin
      state    <= stateNext;
      pendRead <= pendReadNext;
    end
  end

  assign busy = (state == S_WAIT);

endmodule

// File: rtl/bridge_dp.sv
`timescale 1ns/1ps
module bridge_dp
  import bridge_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  input  strobeT                strobe,
  input  logic                  busy,
  input  logic                  ackTog,
  input  logic [DATA_W-1:0]     ackData,
  input  logic                  coreEvt,
  output logic                  reqTog,
  output logic                  holdWr,
  output logic [REG_ADDR_W-1:0] holdAddr,
  output logic [DATA_W-1:0]     holdData,
  output logic                  xferDone,
  output logic [IRQ_SRC_N-1:0]  flags,
  output logic [DATA_W-1:0]     busRdata,
  output logic                  irqReq
);

  localparam int PAD_IRQ = DATA_W - IRQ_SRC_N;

  logic                 ackSync, ackSeen;
  logic                 evtSync, evtPrev, evtRise;
  logic [DATA_W-1:0]    readHold, ctrlShadow, scratch;
  logic [IRQ_SRC_N-1:0] enables, flagsNext, enablesNext;

  bridge_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ackSync (
    .clk(clk), .rstN(rstN), .d(ackTog), .q(ackSync)
  );

  bridge_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_evtSync (
    .clk(clk), .rstN(rstN), .d(coreEvt), .q(evtSync)
  );

  assign xferDone = (ackSync != ackSeen);
  assign evtRise  = evtSync && !evtPrev;

  // payload and request toggle: loaded only when a crossing starts
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqTog   <= 1'b0;
      holdWr   <= 1'b0;
      holdAddr <= '0;
      holdData <= '0;
    end else if (strobe.startXfer) begin
      reqTog   <= !reqTog;
      holdWr   <= strobe.xferWr;
      holdAddr <= busAddr;
      holdData <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackSeen  <= 1'b0;
      evtPrev  <= 1'b0;
      readHold <= '0;
    end else begin
      ackSeen <= ackSync;
      evtPrev <= evtSync;
      if (xferDone && !holdWr) readHold <= ackData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlShadow <= '0;
      scratch    <= '0;
    end else begin
      if (strobe.wrCtrlShadow) ctrlShadow <= busWdata;
      if (strobe.wrScratch)    scratch    <= busWdata;
    end
  end

  // flags: write-one clears, a set in the same cycle wins
  always_comb begin
    flagsNext = flags;
    if (strobe.wrFlag) flagsNext = flagsNext & ~busWdata[IRQ_SRC_N-1:0];
    if (xferDone)      flagsNext[SRC_DONE] = 1'b1;
    if (evtRise)       flagsNext[SRC_EVT]  = 1'b1;
  end

  always_comb begin
    enablesNext = enables;
    if (strobe.wrEnSet) enablesNext = enablesNext | busWdata[IRQ_SRC_N-1:0];
    if (strobe.wrEnClr) enablesNext = enablesNext & ~busWdata[IRQ_SRC_N-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags   <= '0;
      enables <= '0;
    end else begin
      flags   <= flagsNext;
      enables <= enablesNext;
    end
  end

  assign irqReq = |(flags & enables);

  always_comb begin
    unique case (busAddr)
      A_CTRL:          busRdata = ctrlShadow;
      A_STAT, A_PERIOD: busRdata = readHold;
      A_SCRATCH:       busRdata = scratch;
      A_FLAG:          busRdata = {{PAD_IRQ{1'b0}}, flags};
      A_ENSET, A_ENCLR: busRdata = {{PAD_IRQ{1'b0}}, enables};
      A_STATUS:        busRdata = {{(DATA_W-1){1'b0}}, busy};
      default:         busRdata = '0;
    endcase
  end

endmodule

// File: rtl/bridge_core.sv
`timescale 1ns/1ps
module bridge_core
  import bridge_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqTog,
  input  logic                  holdWr,
  input  logic [REG_ADDR_W-1:0] holdAddr,
  input  logic [DATA_W-1:0]     holdData,
  input  logic [DATA_W-1:0]     coreStat,
  output logic                  ackTog,
  output logic [DATA_W-1:0]     ackData,
  output logic [DATA_W-1:0]     coreCtrl,
  output logic [DATA_W-1:0]     corePeriod
);

  logic reqSync, reqSeen, reqNew;

  bridge_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_reqSync (
    .clk(clk), .rstN(rstN), .d(reqTog), .q(reqSync)
  );

  assign reqNew = (reqSync != reqSeen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqSeen    <= 1'b0;
      ackTog     <= 1'b0;
      ackData    <= '0;
      coreCtrl   <= '0;
      corePeriod <= '0;
    end else if (reqNew) begin
      reqSeen <= reqSync;
      ackTog  <= !ackTog;
      if (holdWr) begin
        if (holdAddr == A_CTRL)   coreCtrl   <= holdData;
        if (holdAddr == A_PERIOD) corePeriod <= holdData;
      end else begin
        ackData <= (holdAddr == A_STAT) ? coreStat : corePeriod;
      end
    end
  end

endmodule

// File: rtl/xclk_reg_bridge.sv
`timescale 1ns/1ps
module xclk_reg_bridge
  import bridge_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  busClk,
  input  logic                  busRstN,
  input  logic                  busSel,
  input  logic                  busWrite,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  output logic                  busReady,
  output logic                  irqReq,
  input  logic                  coreClk,
  input  logic                  coreRstN,
  input  logic [DATA_W-1:0]     coreStat,
  input  logic                  coreEvt,
  output logic [DATA_W-1:0]     coreCtrl,
  output logic [DATA_W-1:0]     corePeriod
);

  strobeT                strobe;
  logic                  busyW, xferDone, reqTog, holdWr, ackTog;
  logic [REG_ADDR_W-1:0] holdAddr;
  logic [DATA_W-1:0]     holdDataW, ackData;
  logic [IRQ_SRC_N-1:0]  flagW;

  bridge_ctrl u_ctrl (
    .clk(busClk), .rstN(busRstN),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .xferDone(xferDone),
    .busReady(busReady), .busy(busyW), .strobe(strobe)
  );

  bridge_dp #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(busClk), .rstN(busRstN),
    .busAddr(busAddr), .busWdata(busWdata), .strobe(strobe), .busy(busyW),
    .ackTog(ackTog), .ackData(ackData), .coreEvt(coreEvt),
    .reqTog(reqTog), .holdWr(holdWr), .holdAddr(holdAddr), .holdData(holdDataW),
    .xferDone(xferDone), .flags(flagW), .busRdata(busRdata), .irqReq(irqReq)
  );

  bridge_core #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_core (
    .clk(coreClk), .rstN(coreRstN),
    .reqTog(reqTog), .holdWr(holdWr), .holdAddr(holdAddr), .holdData(holdDataW),
    .coreStat(coreStat),
    .ackTog(ackTog), .ackData(ackData),
    .coreCtrl(coreCtrl), .corePeriod(corePeriod)
  );

endmodule

// File: rtl/bridge_chk.sv
`timescale 1ns/1ps
module bridge_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [2:0]        busAddr,
  input logic              busReady,
  input logic              irqReq,
  input logic              busy,
  input logic [1:0]        flags,
  input logic [DATA_W-1:0] holdData
);

  logic syncWrAcc, syncRdAcc, syncAcc, irqDrop;

  assign syncWrAcc = busSel && busWrite  && (busAddr == 3'd0 || busAddr == 3'd2);
  assign syncRdAcc = busSel && !busWrite && (busAddr == 3'd1 || busAddr == 3'd2);
  assign syncAcc   = syncWrAcc || syncRdAcc;
  assign irqDrop   = busSel && busWrite && busReady && (busAddr == 3'd4 || busAddr == 3'd6);

  p_busy_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    syncWrAcc && busReady |=> busy);

  p_stall_r4: assert property (@(posedge clk) disable iff (!rstN)
    syncAcc && busy |-> !busReady);

  p_plain_ready_r5: assert property (@(posedge clk) disable iff (!rstN)
    busSel && !syncAcc |-> busReady);

  p_done_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> flags[0]);

  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(holdData));

  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqReq && !irqDrop |=> irqReq);

endmodule

bind xclk_reg_bridge bridge_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(busClk), .rstN(busRstN),
  .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
  .busReady(busReady), .irqReq(irqReq),
  .busy(busyW), .flags(flagW), .holdData(holdDataW)
);

// File: tb/test_xclk_reg_bridge.sv
`timescale 1ns/1ps
module test_xclk_reg_bridge;

  localparam logic [2:0] AD_CTRL = 3'd0, AD_STAT = 3'd1, AD_PERIOD = 3'd2, AD_SCRATCH = 3'd3;
  localparam logic [2:0] AD_FLAG = 3'd4, AD_ENSET = 3'd5, AD_ENCLR = 3'd6, AD_STATUS = 3'd7;

  logic        busClk = 1'b0, coreClk = 1'b0;
  logic        busRstN = 1'b0, coreRstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0, coreStat = '0;
  logic        coreEvt = 1'b0;
  logic [31:0] busRdata, coreCtrl, corePeriod;
  logic        busReady, irqReq;

  int checks = 0, failures = 0;
  bit scoreRead = 1'b0, finished = 1'b0;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } expT;
  expT expQ[$];

  always #2   busClk  = ~busClk;   // 250 MHz
  always #3.5 coreClk = ~coreClk;

  xclk_reg_bridge i_xclk_reg_bridge (
    .busClk(busClk), .busRstN(busRstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady),
    .irqReq(irqReq), .coreClk(coreClk), .coreRstN(coreRstN), .coreStat(coreStat),
    .coreEvt(coreEvt), .coreCtrl(coreCtrl), .corePeriod(corePeriod)
  );

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expectation per completed scored read
  always @(negedge busClk) begin
    if (scoreRead && busSel && !busWrite && busReady) begin
      if (expQ.size() == 0) begin
        checks++; failures++;
        $display("FAIL scoreboard empty actual=%h expected=none", busRdata);
      end else begin
        expT e;
        e = expQ.pop_front();
        checkEq(e.tag, busRdata, e.val);
      end
    end
  end

  task automatic busAccess(input logic wr, input logic [2:0] a, input logic [31:0] wd,
                           output logic [31:0] rd, output int waits);
    @(posedge busClk); #1;
    busSel = 1'b1; busWrite = wr; busAddr = a; busWdata = wd;
    waits = 0;
    forever begin
      @(negedge busClk);
      if (busReady || waits > 2000) break;
      waits++;
    end
    rd = busRdata;
    @(posedge busClk); #1;
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, output int waits);
    logic [31:0] unused;
    busAccess(1'b1, a, d, unused, waits);
  endtask

  task automatic rdExp(input logic [2:0] a, input logic [31:0] exp, input string tag, output int waits);
    logic [31:0] rd;
    expQ.push_back('{val: exp, tag: tag});
    scoreRead = 1'b1;
    busAccess(1'b0, a, 32'h0, rd, waits);
    scoreRead = 1'b0;
  endtask

  task automatic waitIdle();
    logic [31:0] rd;
    int w;
    for (int i = 0; i < 200; i++) begin
      busAccess(1'b0, AD_STATUS, 32'h0, rd, w);
      if (rd[0] == 1'b0) break;
    end
  endtask

  task automatic doReset();
    busRstN = 1'b0; coreRstN = 1'b0;
    repeat (4) @(negedge busClk);
    checkEq("R10 irq during reset", {31'b0, irqReq}, 32'h0);
    busRstN = 1'b1; coreRstN = 1'b1;
    repeat (2) @(negedge busClk);
  endtask

  initial begin
    repeat (200000) @(posedge busClk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int w, w2;
    doReset();

    // R10 reset state
    checkEq("R10 ready idle", {31'b0, busReady}, 32'h1);
    checkEq("R10 irq", {31'b0, irqReq}, 32'h0);
    checkEq("R10 coreCtrl", coreCtrl, 32'h0);
    checkEq("R10 corePeriod", corePeriod, 32'h0);
    rdExp(AD_STATUS, 32'h0, "R10 busy", w);
    rdExp(AD_FLAG,   32'h0, "R10 flags", w);
    rdExp(AD_ENSET,  32'h0, "R10 enables", w);

    // R5 / R1 plain scratch register
    wr(AD_SCRATCH, 32'hA5A5_0F0F, w);
    checkEq("R5 scratch write waits", w, 0);
    rdExp(AD_SCRATCH, 32'hA5A5_0F0F, "R1 scratch readback", w);
    checkEq("R5 scratch read waits", w, 0);
    rdExp(AD_STATUS, 32'h0, "R1 scratch no busy", w);

    // R1 / R2 / R3 write-synced control
    wr(AD_CTRL, 32'h0000_1234, w);
    checkEq("R1 ctrl write posted", w, 0);
    rdExp(AD_STATUS, 32'h1, "R2 busy after ctrl write", w);
    waitIdle();
    checkEq("R3 coreCtrl applied when idle", coreCtrl, 32'h0000_1234);
    rdExp(AD_CTRL, 32'h0000_1234, "R1 ctrl readback", w);
    rdExp(AD_FLAG, 32'h1, "R7 done flag", w);

    // R7 write-one clear
    wr(AD_FLAG, 32'h0, w);
    rdExp(AD_FLAG, 32'h1, "R7 zero write keeps flag", w);
    wr(AD_FLAG, 32'h1, w);
    rdExp(AD_FLAG, 32'h0, "R7 one write clears flag", w);

    // R4 / R5 stall on a second crossing, plain access passes
    wr(AD_CTRL, 32'h0000_0011, w);
    wr(AD_SCRATCH, 32'h0000_0055, w2);
    checkEq("R5 scratch during busy waits", w2, 0);
    wr(AD_PERIOD, 32'h0000_0022, w);
    checkEq("R4 period write stalled", {31'b0, (w > 0)}, 32'h1);
    waitIdle();
    checkEq("R4 coreCtrl after stall", coreCtrl, 32'h0000_0011);
    checkEq("R4 corePeriod after stall", corePeriod, 32'h0000_0022);
    rdExp(AD_SCRATCH, 32'h0000_0055, "R5 scratch during busy", w);

    // R6 read-synced status and both-synced period
    coreStat = 32'hCAFE_F00D;
    rdExp(AD_STAT, 32'hCAFE_F00D, "R6 core status read", w);
    checkEq("R6 status read stalls", {31'b0, (w > 0)}, 32'h1);
    rdExp(AD_PERIOD, 32'h0000_0022, "R6 period read", w);
    wr(AD_STAT, 32'h1111_1111, w);
    checkEq("R1 stat write ignored waits", w, 0);
    rdExp(AD_STAT, 32'hCAFE_F00D, "R1 stat write ignored", w);

    // R4 read arriving while write in flight
    wr(AD_PERIOD, 32'h0000_0077, w);
    rdExp(AD_PERIOD, 32'h0000_0077, "R4 stalled period read", w);
    checkEq("R4 read stalled", {31'b0, (w > 0)}, 32'h1);

    // R8 enables
    wr(AD_ENSET, 32'h2, w);
    rdExp(AD_ENSET, 32'h2, "R8 enable set", w);
    wr(AD_ENSET, 32'h0, w);
    wr(AD_ENCLR, 32'h0, w);
    rdExp(AD_ENCLR, 32'h2, "R8 zero writes no effect", w);

    // R9 request line (flag 0 is set from the last crossing)
    @(negedge busClk);
    checkEq("R9 masked flag no irq", {31'b0, irqReq}, 32'h0);
    wr(AD_ENSET, 32'h1, w);
    @(negedge busClk);
    checkEq("R9 irq on enable", {31'b0, irqReq}, 32'h1);
    wr(AD_FLAG, 32'h0, w);
    @(negedge busClk);
    checkEq("R9 irq held", {31'b0, irqReq}, 32'h1);
    wr(AD_ENCLR, 32'h1, w);
    @(negedge busClk);
    checkEq("R9 irq off on disable", {31'b0, irqReq}, 32'h0);
    wr(AD_ENSET, 32'h1, w);
    wr(AD_FLAG, 32'h1, w);
    @(negedge busClk);
    checkEq("R9 irq off on flag clear", {31'b0, irqReq}, 32'h0);

    // R7 event flag
    @(negedge coreClk); coreEvt = 1'b1;
    repeat (3) @(negedge coreClk); coreEvt = 1'b0;
    repeat (8) @(negedge busClk);
    rdExp(AD_FLAG, 32'h2, "R7 event flag", w);
    @(negedge busClk);
    checkEq("R9 irq from event", {31'b0, irqReq}, 32'h1);
    repeat (8) @(negedge busClk);
    rdExp(AD_FLAG, 32'h2, "R7 no retrigger while high", w);
    wr(AD_FLAG, 32'h2, w);
    @(negedge busClk);
    checkEq("R9 irq after event clear", {31'b0, irqReq}, 32'h0);

    // R10 reset in mid-run
    @(negedge coreClk); coreEvt = 1'b1;
    repeat (2) @(negedge coreClk); coreEvt = 1'b0;
    repeat (8) @(negedge busClk);
    checkEq("R9 irq before reset", {31'b0, irqReq}, 32'h1);
    doReset();
    checkEq("R10 irq after reset", {31'b0, irqReq}, 32'h0);
    checkEq("R10 coreCtrl after reset", coreCtrl, 32'h0);
    rdExp(AD_ENSET, 32'h0, "R10 enables after reset", w);
    rdExp(AD_FLAG,  32'h0, "R10 flags after reset", w);

    repeat (4) @(negedge busClk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule